// File: doc/BRIEF.md
# Byte-Wide Indirect Coefficient Access Port

This block connects a narrow host bus, which carries 8 bits per access, to a wide coefficient register that lives deeper inside the chip and has no host address of its own. The host never touches that register directly. It fills a staging buffer one byte at a time, and then accesses a single command location that moves the whole word in one step.

A host write to the command location presents the staging buffer on a 22-bit parallel output, together with a one-cycle load strobe, so the internal register takes all 22 bits at once. A host read of the command location captures the 22-bit parallel input into the staging buffer. The host then reads the captured value back one byte at a time. The data byte of a command write is discarded, and the byte returned by a command read is zero.

Only the staging buffer, the byte lane mapping and the copy trigger are in this block. The register that consumes the coefficient sits outside it.

Top module: `coef_port_top`

## Requirements
- R1: While reset is high and after it is released, every staging buffer byte reads as 0x00 and `coef_load` is low.
- R2: A host write to offset 0, 1 or 2 stores the data byte in the matching lane of the staging buffer. Offset 0 holds bits 7:0 and offset 2 holds the top bits. A read of that offset from the next cycle on returns the stored value.
- R3: The lane at offset 2 keeps only bits 21:16, which are 6 bits. Bits 7:6 of a write to that offset are dropped, and bits 7:6 of a read from it are always zero.
- R4: A host write to the command offset 3 raises `coef_load` in that same cycle, with `coef_wdata` equal to the full staging buffer. The data byte has no effect on any buffer lane.
- R5: A host read of the command offset 3 returns 0x00 in that cycle and loads `coef_rdata` into the staging buffer at the clock edge. Byte reads from the next cycle on return the new value.
- R6: `coef_load` is high only in a cycle where `bus_wr` is high and `bus_addr` equals 3.
- R7: Offsets 4 and above are unmapped. Reads from them return 0x00, and writes to them leave the staging buffer unchanged and do not raise `coef_load`.
- R8: When `bus_wr` and `bus_rd` are both high at offset 3, `coef_load` carries the buffer value held before that edge, and the buffer then takes `coef_rdata`.
- R9: `bus_rdata` follows the addressed byte in the same cycle as `bus_rd`, with no wait state. It is 0x00 whenever `bus_rd` is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Host byte offset: 0 to 2 are buffer lanes, 3 is the command location |
| bus_wdata | input | 8 | Host write data |
| bus_wr | input | 1 | Host write strobe, one cycle per access |
| bus_rd | input | 1 | Host read strobe, one cycle per access |
| bus_rdata | output | 8 | Host read data, valid in the strobe cycle |
| coef_load | output | 1 | Load strobe toward the internal coefficient register |
| coef_wdata | output | 22 | Staging buffer contents, to be loaded when `coef_load` is high |
| coef_rdata | input | 22 | Current value of the internal coefficient register |

## Verification
Two functions can land in the same clock edge: the copy out to the internal register and the capture back into the staging buffer. This happens when the host raises both strobes at the command offset. The bench provokes it with a buffer value and a `coef_rdata` value that differ in every byte. It then checks that the load strobe carried the old buffer and that the later byte reads return the captured value. A full round trip is also run: buffer to register, buffer wiped, register back to buffer. This round trip shows that all 22 bits survive the byte mapping in both directions.

// File: rtl/coef_port_pkg.sv
package coef_port_pkg;

    localparam int BYTE_W = 8;

    // kind of host access after decoding
    typedef enum logic [2:0] {
        ACC_NONE     = 3'd0,
        ACC_LANE     = 3'd1,
        ACC_COPY     = 3'd2,
        ACC_UNMAPPED = 3'd3
    } acc_kind_t;

    // decoded command-location activity for one cycle
    typedef struct packed {
        logic      copy_out;   // buffer -> internal register
        logic      copy_in;    // internal register -> buffer
        acc_kind_t kind;
    } acc_cmd_t;

    function automatic int lane_count(input int w);
        return (w + BYTE_W - 1) / BYTE_W;
    endfunction

    function automatic int lane_bits(input int w, input int k);
        int r;
        r = w - k * BYTE_W;
        if (r > BYTE_W) r = BYTE_W;
        return r;
    endfunction

endpackage

// File: rtl/coef_addr_decode.sv
module coef_addr_decode
    import coef_port_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int LANES  = 3
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic              rd,
    output logic [LANES-1:0]  lane_we,
    output logic [LANES-1:0]  lane_re,
    output acc_cmd_t          cmd
);

    localparam logic [ADDR_W-1:0] COPY_OFS = ADDR_W'(LANES);

    logic is_copy;
    logic is_lane;

    assign is_copy = (addr == COPY_OFS);
    assign is_lane = (addr < COPY_OFS);

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        assign lane_we[k] = wr && (addr == ADDR_W'(k));
        assign lane_re[k] = rd && (addr == ADDR_W'(k));
    end

    always_comb begin
        cmd.copy_out = wr && is_copy;
        cmd.copy_in  = rd && is_copy;
        if (!(wr || rd))  cmd.kind = ACC_NONE;
        else if (is_lane) cmd.kind = ACC_LANE;
        else if (is_copy) cmd.kind = ACC_COPY;
        else              cmd.kind = ACC_UNMAPPED;
    end

endmodule

// File: rtl/coef_stage_buf.sv
module coef_stage_buf
    import coef_port_pkg::*;
#(
    parameter int COEF_W = 22,
    parameter int LANES  = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [LANES-1:0]  lane_we,
    input  logic [LANES-1:0]  lane_re,
    input  logic [7:0]        wdata,
    input  logic              capture,
    input  logic [COEF_W-1:0] capture_val,
    output logic [7:0]        rdata,
    output logic [COEF_W-1:0] buf_q
);

    localparam int TOP_BITS = lane_bits(COEF_W, LANES - 1);

    logic [LANES-1:0][7:0] lane_byte;
    logic [LANES-1:0][7:0] lane_masked;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        localparam int LO = k * BYTE_W;
        localparam int LB = lane_bits(COEF_W, k);

        logic [LB-1:0] lane_q;

        always_ff @(posedge clk) begin
            if (rst)             lane_q <= '0;
            else if (capture)    lane_q <= capture_val[LO +: LB];
            else if (lane_we[k]) lane_q <= wdata[LB-1:0];
        end

        assign buf_q[LO +: LB] = lane_q;
        assign lane_byte[k]    = 8'(lane_q);
        assign lane_masked[k]  = lane_re[k] ? lane_byte[k] : 8'h00;

        // a lone lane write is held in that lane on the next cycle
        assert_lane_write_R2: assert property (@(posedge clk) disable iff (rst)
            (lane_we[k] && !capture) |=> (lane_q == $past(wdata[LB-1:0])));
    end

    always_comb begin
        rdata = 8'h00;
        for (int k = 0; k < LANES; k++) rdata = rdata | lane_masked[k];
    end

    // the top lane never shows bits beyond the coefficient width
    assert_top_lane_narrow_R3: assert property (@(posedge clk) disable iff (rst)
        lane_re[LANES-1] |-> ((rdata >> TOP_BITS) == 8'h00));

endmodule

// File: rtl/coef_port_top.sv
module coef_port_top
    import coef_port_pkg::*;
#(
    parameter int COEF_W = 22,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [7:0]        bus_wdata,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [7:0]        bus_rdata,
    output logic              coef_load,
    output logic [COEF_W-1:0] coef_wdata,
    input  logic [COEF_W-1:0] coef_rdata
);

    localparam int LANES = lane_count(COEF_W);
    localparam logic [ADDR_W-1:0] COPY_OFS = ADDR_W'(LANES);

    logic [LANES-1:0]  lane_we;
    logic [LANES-1:0]  lane_re;
    acc_cmd_t          cmd;
    logic [7:0]        buf_rdata;
    logic [COEF_W-1:0] buf_q;

    coef_addr_decode #(.ADDR_W(ADDR_W), .LANES(LANES)) u_dec (
        .addr    (bus_addr),
        .wr      (bus_wr),
        .rd      (bus_rd),
        .lane_we (lane_we),
        .lane_re (lane_re),
        .cmd     (cmd)
    );

    coef_stage_buf #(.COEF_W(COEF_W), .LANES(LANES)) u_buf (
        .clk         (clk),
        .rst         (rst),
        .lane_we     (lane_we),
        .lane_re     (lane_re),
        .wdata       (bus_wdata),
        .capture     (cmd.copy_in),
        .capture_val (coef_rdata),
        .rdata       (buf_rdata),
        .buf_q       (buf_q)
    );

    assign coef_load  = cmd.copy_out;
    assign coef_wdata = buf_q;
    assign bus_rdata  = (cmd.kind == ACC_LANE && bus_rd) ? buf_rdata : 8'h00;

    // load strobe appears only for a write to the command location
    assert_load_only_copy_R6: assert property (@(posedge clk) disable iff (rst)
        coef_load |-> (bus_wr && bus_addr == COPY_OFS));

    // a command write alone leaves the buffer untouched
    assert_copy_out_keeps_buf_R4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && bus_addr == COPY_OFS) |=> $stable(coef_wdata));

    // a command read captures the register value into the buffer
    assert_copy_in_capture_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == COPY_OFS) |=> (coef_wdata == $past(coef_rdata)));

    // the command location reads as zero
    assert_copy_reads_zero_R5: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == COPY_OFS) |-> (bus_rdata == 8'h00));

    // unmapped offsets have no effect
    assert_unmapped_quiet_R7: assert property (@(posedge clk) disable iff (rst)
        ((bus_wr || bus_rd) && bus_addr > COPY_OFS) |=> $stable(coef_wdata));

    // both strobes on the command location: the load fires as well
    assert_dual_copy_load_R8: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_rd && bus_addr == COPY_OFS) |-> coef_load);

    // no read strobe, no read data
    assert_idle_rdata_R9: assert property (@(posedge clk) disable iff (rst)
        !bus_rd |-> (bus_rdata == 8'h00));

endmodule

// File: tb/tb_coef_port_top.sv
module tb_coef_port_top;

    logic        clk = 1'b0;
    logic        rst;
    logic [3:0]  bus_addr;
    logic [7:0]  bus_wdata;
    logic        bus_wr;
    logic        bus_rd;
    logic [7:0]  bus_rdata;
    logic        coef_load;
    logic [21:0] coef_wdata;
    logic [21:0] coef_rdata;

    logic [21:0] int_reg;
    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    coef_port_top dut (
        .clk        (clk),
        .rst        (rst),
        .bus_addr   (bus_addr),
        .bus_wdata  (bus_wdata),
        .bus_wr     (bus_wr),
        .bus_rd     (bus_rd),
        .bus_rdata  (bus_rdata),
        .coef_load  (coef_load),
        .coef_wdata (coef_wdata),
        .coef_rdata (coef_rdata)
    );

    // bench model of the internal register the port feeds
    always @(posedge clk) if (coef_load) int_reg <= coef_wdata;

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // one bus cycle; samples combinational outputs mid-cycle
    task automatic bus_cycle(input logic [3:0] a, input logic [7:0] d, input bit w,
                             input bit r, output logic [7:0] rd_o, output logic ld_o,
                             output logic [21:0] ldv_o);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = w; bus_rd = r;
        #1;
        rd_o = bus_rdata; ld_o = coef_load; ldv_o = coef_wdata;
        @(posedge clk);
        #1;
        bus_wr = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic wr_byte(input logic [3:0] a, input logic [7:0] d);
        logic [7:0] r; logic l; logic [21:0] v;
        bus_cycle(a, d, 1'b1, 1'b0, r, l, v);
    endtask

    task automatic rd_byte(input logic [3:0] a, output logic [7:0] d);
        logic l; logic [21:0] v;
        bus_cycle(a, 8'h00, 1'b0, 1'b1, d, l, v);
    endtask

    task automatic read_buf(output logic [21:0] v);
        logic [7:0] b0, b1, b2;
        rd_byte(4'd0, b0); rd_byte(4'd1, b1); rd_byte(4'd2, b2);
        v = {b2[5:0], b1, b0};
    endtask

    task automatic t_reset();
        logic [7:0] b;
        for (int k = 0; k < 3; k++) begin
            rd_byte(4'(k), b);
            check(b == 8'h00, "R1 buffer byte after reset", b, 0);
        end
        check(coef_load == 1'b0, "R1 load low after reset", coef_load, 0);
    endtask

    task automatic t_lanes();
        logic [7:0] b;
        wr_byte(4'd0, 8'h11); wr_byte(4'd1, 8'h22); wr_byte(4'd2, 8'hFF);
        rd_byte(4'd0, b); check(b == 8'h11, "R2 lane0", b, 8'h11);
        rd_byte(4'd1, b); check(b == 8'h22, "R2 lane1", b, 8'h22);
        rd_byte(4'd2, b); check(b == 8'h3F, "R3 top lane masked", b, 8'h3F);
        check(coef_wdata == 22'h3F2211, "R2 lane order", coef_wdata, 22'h3F2211);
    endtask

    task automatic t_idle_rdata();
        @(negedge clk);
        bus_addr = 4'd0;
        #1;
        check(bus_rdata == 8'h00, "R9 rdata idle", bus_rdata, 0);
    endtask

    task automatic t_copy_out();
        logic [7:0] r; logic l; logic [21:0] v, after;
        bus_cycle(4'd3, 8'hA5, 1'b1, 1'b0, r, l, v);
        check(l == 1'b1, "R4 load same cycle", l, 1);
        check(v == 22'h3F2211, "R4 load value", v, 22'h3F2211);
        check(int_reg == 22'h3F2211, "R4 register took word", int_reg, 22'h3F2211);
        read_buf(after);
        check(after == 22'h3F2211, "R4 data byte ignored", after, 22'h3F2211);
    endtask

    task automatic t_copy_in();
        logic [7:0] r; logic l; logic [21:0] v, after;
        coef_rdata = 22'h2ABCDE;
        bus_cycle(4'd3, 8'h00, 1'b0, 1'b1, r, l, v);
        check(r == 8'h00, "R5 command read zero", r, 0);
        check(l == 1'b0, "R6 no load on command read", l, 0);
        read_buf(after);
        check(after == 22'h2ABCDE, "R5 captured word", after, 22'h2ABCDE);
    endtask

    task automatic t_round_trip();
        logic [21:0] after;
        wr_byte(4'd0, 8'h5A); wr_byte(4'd1, 8'hC3); wr_byte(4'd2, 8'h29);
        wr_byte(4'd3, 8'h00);
        coef_rdata = int_reg;
        wr_byte(4'd0, 8'h00); wr_byte(4'd1, 8'h00); wr_byte(4'd2, 8'h00);
        read_buf(after);
        check(after == 22'h0, "R2 buffer wiped", after, 0);
        begin
            logic [7:0] r;
            rd_byte(4'd3, r);
        end
        read_buf(after);
        check(after == 22'h29C35A, "R5 round trip all 22 bits", after, 22'h29C35A);
    endtask

    task automatic t_unmapped();
        logic [7:0] r; logic l; logic [21:0] v, after;
        bus_cycle(4'd7, 8'hFF, 1'b1, 1'b0, r, l, v);
        check(l == 1'b0, "R7 no load on unmapped write", l, 0);
        bus_cycle(4'd9, 8'h00, 1'b0, 1'b1, r, l, v);
        check(r == 8'h00, "R7 unmapped read zero", r, 0);
        read_buf(after);
        check(after == 22'h29C35A, "R7 buffer unchanged", after, 22'h29C35A);
    endtask

    task automatic t_dual();
        logic [7:0] r; logic l; logic [21:0] v, after;
        coef_rdata = 22'h15A6F0;
        bus_cycle(4'd3, 8'h77, 1'b1, 1'b1, r, l, v);
        check(l == 1'b1, "R8 load on dual strobe", l, 1);
        check(v == 22'h29C35A, "R8 load carries old buffer", v, 22'h29C35A);
        check(int_reg == 22'h29C35A, "R8 register took old buffer", int_reg, 22'h29C35A);
        read_buf(after);
        check(after == 22'h15A6F0, "R8 buffer took input", after, 22'h15A6F0);
    endtask

    initial begin
        rst = 1'b1; bus_addr = '0; bus_wdata = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        coef_rdata = '0; int_reg = '0;
        repeat (3) @(posedge clk);
        #1;
        check(coef_load == 1'b0, "R1 load low in reset", coef_load, 0);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_lanes();
        t_idle_rdata();
        t_copy_out();
        t_copy_in();
        t_round_trip();
        t_unmapped();
        t_dual();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=0x0 expected=0x1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule